// File: doc/BRIEF.md
# DMA Working Address and Byte Counter

This block holds the working state of a bus-master DMA engine: a 32-bit memory address and a 12-bit remaining-byte count. The address is kept as two 16-bit halves. The count is stored as a negative two's complement number that rises toward zero. Each increment strobe from the bus interface moves the address to the next byte and brings the count one step closer to zero. When the count wraps from all ones to zero, a one-cycle done flag marks that the buffer is used up.

Software reaches the halves and the counter through a small host register port. That port is live only while the controller is stopped. A test-enable input turns every accepted host write into a load followed by one increment in the next cycle. This lets the counters be stepped without running any bus traffic.

Top module: `dma_xfer_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, the address and count clear to zero, `count_done` goes low and any pending test increment is dropped.
- R2: A write (`reg_wr` high while `stopped` is high) loads the register chosen by `reg_sel` at the clock edge. Code 0 loads address bits 15:0 from `reg_wdata`. Code 1 loads address bits 31:16. Code 2 loads the count from `reg_wdata[11:0]`, and `reg_wdata[15:12]` is ignored. Code 3 selects no register, and a write to it changes nothing.
- R3: A read (`reg_rd` high while `stopped` is high) returns the selected value on `reg_rdata` in the same cycle. A count read returns bits 15:12 as 4'b1111 above the 12-bit count. Code 3 reads as zero.
- R4: While `stopped` is low, writes change nothing and `reg_rdata` is zero. `reg_rdata` is also zero whenever `reg_rd` is low.
- R5: An increment adds 1 to the full 32-bit address. The carry passes from bit 15 into bit 16, and the address wraps from all ones to zero.
- R6: The same increment adds 1 to the 12-bit count, which wraps from 12'hFFF to 12'h000.
- R7: `count_done` is high for exactly one cycle: the cycle after the edge at which an increment wraps the count from 12'hFFF to zero.
- R8: When `test_en` is high during an accepted write, exactly one increment of both address and count is applied at the next edge, unless R9 applies at that edge.
- R9: A cycle that carries an accepted write performs no increment. An `inc` strobe in that cycle is discarded, and so is a test increment pending from the previous write.
- R10: In a cycle with no accepted write, no `inc` and no pending test increment, the address and count hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stopped | input | 1 | Controller is stopped; host access enabled |
| test_en | input | 1 | Test mode: each write is followed by one increment |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_sel | input | 2 | Register select: 0 addr low, 1 addr high, 2 count, 3 none |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data (combinational) |
| inc | input | 1 | Increment strobe from the bus interface |
| addr | output | 32 | Current DMA memory address |
| count | output | 12 | Remaining byte count, negative two's complement |
| count_done | output | 1 | One-cycle pulse when the count wraps to zero |

## Verification
A broken carry between the halves or a wrong count adder shows on `addr` or `count` at the very next edge after a strobe. A stuck pending test increment shows as an extra step one cycle after a test-mode write. Lost gating shows as a changed register or a non-zero `reg_rdata` right after an access made while running. The count is swept over all 4096 values, with a read-back and one increment for each value, so every wrap and every done pulse is seen. The address is swept over its carry and wrap corners in both halves.

// File: rtl/dma_regs_pkg.sv
// Package: shared constants and the register-select encoding of the
// DMA working-register block.
package dma_regs_pkg;
    localparam int NUM_HALVES = 2;

    typedef enum logic [1:0] {
        SEL_ADDR_LO = 2'd0,
        SEL_ADDR_HI = 2'd1,
        SEL_COUNT   = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/dma_access_ctl.sv
// dma_access_ctl: gates host accesses with the stop state, decodes the
// register select, and merges bus strobes with test-mode increments.
// Assumes: a write always wins over an increment in the same cycle.
module dma_access_ctl
    import dma_regs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stopped,
    input  logic                  test_en,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [1:0]            reg_sel,
    input  logic                  inc,
    output logic [NUM_HALVES-1:0] wr_half,
    output logic                  wr_cnt,
    output logic                  rd_en,
    output logic                  step
);
    reg_sel_e sel;
    logic     wr_ok;
    logic     any_wr;
    logic     pend_q;

    assign sel = reg_sel_e'(reg_sel);

    // Purpose: accept host accesses only while the controller is stopped.
    always_comb begin
        wr_ok   = reg_wr && stopped;
        rd_en   = reg_rd && stopped;
        wr_half = '0;
        wr_cnt  = 1'b0;
        unique case (sel)
            SEL_ADDR_LO: wr_half[0] = wr_ok;
            SEL_ADDR_HI: wr_half[1] = wr_ok;
            SEL_COUNT:   wr_cnt     = wr_ok;
            default:     ;
        endcase
        any_wr = (|wr_half) || wr_cnt;
        step   = !any_wr && (inc || pend_q);
    end

    // Purpose: remember that a test-mode write owes one increment.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= any_wr && test_en;
    end

    // R4: nothing is written while the controller runs
    a_r4_no_write_running: assert property (@(posedge clk) disable iff (!rst_n)
        !stopped |-> (wr_half == '0) && !wr_cnt);
    // R9: a write cycle never steps
    a_r9_write_beats_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((|wr_half) || wr_cnt) |-> !step);
    // R8: a test-mode write is followed by a step unless another write comes
    a_r8_test_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(((|wr_half) || wr_cnt) && test_en) && !((|wr_half) || wr_cnt)) |-> step);
endmodule

// File: rtl/dma_addr_ctr.sv
// dma_addr_ctr: the DMA memory address, built from NUM_HALVES halves of
// HALF_W bits. Each half is loaded separately; a step adds 1 to the whole
// address, so the carry crosses the half boundaries.
// Assumes: wr_half and step are never high together.
module dma_addr_ctr
    import dma_regs_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_HALVES-1:0]        wr_half,
    input  logic [HALF_W-1:0]            wdata,
    input  logic                         step,
    output logic [NUM_HALVES*HALF_W-1:0] addr
);
    localparam int AW = NUM_HALVES * HALF_W;

    logic [AW-1:0] q;
    logic [AW-1:0] q_inc;
    logic [AW-1:0] d;

    assign q_inc = q + AW'(1);

    // Purpose: choose the next value of each half (load, step or hold).
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        assign d[h*HALF_W +: HALF_W] = wr_half[h] ? wdata :
                                       step       ? q_inc[h*HALF_W +: HALF_W] :
                                                    q[h*HALF_W +: HALF_W];
    end

    // Purpose: hold the address register.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign addr = q;

    // R5: a step adds one across the full width
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(step)) |-> q == $past(q) + AW'(1));
    // R10: with no step and no load the address holds
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(step) && $past(wr_half) == '0) |-> $stable(q));
    // R2: a low-half load takes the write data
    a_r2_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_half[0])) |-> q[HALF_W-1:0] == $past(wdata));
endmodule

// File: rtl/dma_byte_ctr.sv
// dma_byte_ctr: remaining byte count kept as a negative two's complement
// number that a step raises toward zero; flags the wrap to zero.
// Assumes: wr and step are never high together.
module dma_byte_ctr #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             done
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] q;
    logic             done_q;

    // Purpose: load, step or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (wr)   q <= wdata;
        else if (step) q <= q + CNT_W'(1);
    end

    // Purpose: pulse done for the cycle after a step wraps the count.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= step && (q == ALL_ONES);
    end

    assign count = q;
    assign done  = done_q;

    // R6: a step adds one modulo the count width
    a_r6_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(step)) |-> q == $past(q) + CNT_W'(1));
    // R7: done is only seen with a zero count and lasts one cycle
    a_r7_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> q == '0);
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/dma_xfer_regs.sv
// dma_xfer_regs: top of the DMA working-register block. Joins access
// control, the address counter and the byte counter, and forms read data.
// Assumes: reg_sel is stable while reg_rd is high.
module dma_xfer_regs
    import dma_regs_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         stopped,
    input  logic                         test_en,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [1:0]                   reg_sel,
    input  logic [HALF_W-1:0]            reg_wdata,
    output logic [HALF_W-1:0]            reg_rdata,
    input  logic                         inc,
    output logic [NUM_HALVES*HALF_W-1:0] addr,
    output logic [CNT_W-1:0]             count,
    output logic                         count_done
);
    localparam int PAD_W = HALF_W - CNT_W;

    logic [NUM_HALVES-1:0] wr_half;
    logic                  wr_cnt;
    logic                  rd_en;
    logic                  step;

    dma_access_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .stopped (stopped),
        .test_en (test_en),
        .reg_wr  (reg_wr),
        .reg_rd  (reg_rd),
        .reg_sel (reg_sel),
        .inc     (inc),
        .wr_half (wr_half),
        .wr_cnt  (wr_cnt),
        .rd_en   (rd_en),
        .step    (step)
    );

    dma_addr_ctr #(.HALF_W(HALF_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_half (wr_half),
        .wdata   (reg_wdata),
        .step    (step),
        .addr    (addr)
    );

    dma_byte_ctr #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_cnt),
        .wdata (reg_wdata[CNT_W-1:0]),
        .step  (step),
        .count (count),
        .done  (count_done)
    );

    // Purpose: form host read data, zero unless a gated read is under way.
    always_comb begin
        reg_rdata = '0;
        if (rd_en) begin
            unique case (reg_sel_e'(reg_sel))
                SEL_ADDR_LO: reg_rdata = addr[HALF_W-1:0];
                SEL_ADDR_HI: reg_rdata = addr[2*HALF_W-1:HALF_W];
                SEL_COUNT:   reg_rdata = {{PAD_W{1'b1}}, count};
                default:     reg_rdata = '0;
            endcase
        end
    end

    // R3: count reads carry ones above the count
    a_r3_count_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && stopped && reg_sel == 2'd2) |-> reg_rdata == {{PAD_W{1'b1}}, count});
    // R4: no gated read, no data
    a_r4_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && stopped) |-> reg_rdata == '0);
endmodule

// File: tb/dma_xfer_regs_test.sv
// dma_xfer_regs_test: self-checking bench; sweeps every count value and
// the address carry corners, then covers gating, test mode and priority.
module dma_xfer_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        stopped, test_en, reg_wr, reg_rd, inc;
    logic [1:0]  reg_sel;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic [31:0] addr;
    logic [11:0] count;
    logic        count_done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    dma_xfer_regs uut (
        .clk(clk), .rst_n(rst_n), .stopped(stopped), .test_en(test_en),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .inc(inc),
        .addr(addr), .count(count), .count_done(count_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // One write cycle, optionally with an inc strobe in the same cycle.
    task automatic wr(input logic [1:0] s, input logic [15:0] d, input logic with_inc);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d; inc = with_inc;
        tick();
        reg_wr = 1'b0; inc = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] v);
        reg_rd = 1'b1; reg_sel = s;
        #1 v = reg_rdata;
        reg_rd = 1'b0;
        #1;
    endtask

    task automatic pulse_inc();
        inc = 1'b1;
        tick();
        inc = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got %0d expected 0", WATCHDOG);
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [31:0] a0;
        logic [11:0] c0;
        rst_n = 1'b0; stopped = 1'b1; test_en = 1'b0; reg_wr = 1'b0;
        reg_rd = 1'b0; inc = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1 addr", addr, 32'h0);
        chk("R1 count", {20'h0, count}, 32'h0);
        chk("R1 done", {31'h0, count_done}, 32'h0);
        rd(2'd2, v);
        chk("R1 R3 count read", {16'h0, v}, 32'h0000F000);

        // R2 R3 R6 R7: every count value, read back and stepped once
        for (int c = 0; c < 4096; c++) begin
            wr(2'd2, {c[3:0], c[11:0]}, 1'b0);
            rd(2'd2, v);
            chk("R2 R3 count load/read", {16'h0, v}, {16'h0, 4'hF, c[11:0]});
            pulse_inc();
            chk("R6 count step", {20'h0, count}, {20'h0, 12'(c + 1)});
            chk("R7 done pulse", {31'h0, count_done}, {31'h0, c == 4095});
            if (c == 4095) begin
                tick();
                chk("R7 done one cycle", {31'h0, count_done}, 32'h0);
            end
        end

        // R2 R3 R5: address carry and wrap corners in both halves
        for (int hi = 0; hi < 8; hi++) begin
            for (int lo = 0; lo < 8; lo++) begin
                logic [15:0] h, l;
                h = 16'(16'hFFF8 + hi);
                l = 16'(16'hFFF8 + lo);
                wr(2'd0, l, 1'b0);
                wr(2'd1, h, 1'b0);
                rd(2'd0, v);
                chk("R3 addr lo read", {16'h0, v}, {16'h0, l});
                rd(2'd1, v);
                chk("R3 addr hi read", {16'h0, v}, {16'h0, h});
                pulse_inc();
                chk("R5 addr step", addr, {h, l} + 32'd1);
            end
        end

        // R10: idle cycles hold the state
        a0 = addr; c0 = count;
        repeat (3) tick();
        chk("R10 addr hold", addr, a0);
        chk("R10 count hold", {20'h0, count}, {20'h0, c0});

        // R2 R3: select code 3 is no register
        wr(2'd3, 16'h5A5A, 1'b0);
        chk("R2 sel3 addr", addr, a0);
        chk("R2 sel3 count", {20'h0, count}, {20'h0, c0});
        rd(2'd3, v);
        chk("R3 sel3 read", {16'h0, v}, 32'h0);

        // R4: running controller ignores writes and reads zero
        stopped = 1'b0;
        wr(2'd0, 16'hABCD, 1'b0);
        wr(2'd2, 16'h0123, 1'b0);
        chk("R4 addr unchanged", addr, a0);
        chk("R4 count unchanged", {20'h0, count}, {20'h0, c0});
        rd(2'd0, v);
        chk("R4 read zero lo", {16'h0, v}, 32'h0);
        rd(2'd2, v);
        chk("R4 read zero cnt", {16'h0, v}, 32'h0);
        pulse_inc();
        chk("R4 R5 inc while running", addr, a0 + 32'd1);
        stopped = 1'b1;

        // R8: test-mode write is followed by one increment
        test_en = 1'b1;
        wr(2'd1, 16'h1234, 1'b0);
        wr(2'd2, 16'h07FF, 1'b0);
        a0 = addr;
        chk("R8 count loaded", {20'h0, count}, 32'h7FF);
        tick();
        chk("R8 count stepped", {20'h0, count}, 32'h800);
        chk("R8 addr stepped", addr, a0 + 32'd1);
        tick();
        chk("R8 single step", {20'h0, count}, 32'h800);
        wr(2'd0, 16'hFFFF, 1'b0);
        tick();
        chk("R8 R5 test carry", addr, 32'h12350000);
        wr(2'd2, 16'h0FFF, 1'b0);
        tick();
        chk("R8 R7 test wrap done", {31'h0, count_done}, 32'h1);

        // R9: write beats a same-cycle strobe
        test_en = 1'b0;
        c0 = count;
        wr(2'd0, 16'h0040, 1'b1);
        chk("R9 write wins lo", {16'h0, addr[15:0]}, 32'h40);
        chk("R9 strobe dropped", {20'h0, count}, {20'h0, c0});
        // R9: back-to-back test writes drop the first pending step
        test_en = 1'b1;
        wr(2'd0, 16'h0100, 1'b0);
        wr(2'd2, 16'h0A00, 1'b0);
        chk("R9 pending dropped lo", {16'h0, addr[15:0]}, 32'h100);
        chk("R9 second load", {20'h0, count}, 32'hA00);
        tick();
        chk("R9 R8 late step lo", {16'h0, addr[15:0]}, 32'h101);
        chk("R9 R8 late step cnt", {20'h0, count}, 32'hA01);
        test_en = 1'b0;

        // R1: reset clears a loaded state
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk("R1 reset addr", addr, 32'h0);
        chk("R1 reset count", {20'h0, count}, 32'h0);
        tick();
        chk("R1 no pending after reset", addr, 32'h0);

        summary();
        $finish;
    end
endmodule